// File: doc/BRIEF.md
# Host Parallel Port Bridge

This block lets an external host with an 8-bit asynchronous bus exchange 24-bit words with a processor. In the host-to-processor direction, the host writes a word one byte at a time into high, middle and low byte registers. The write of the low byte hands the assembled word to the processor over a valid/ready handshake. In the processor-to-host direction, the processor loads a word over a second valid/ready handshake, and the host reads it back one byte at a time.

Two flags pace the host:
- a word-pending flag, set while a host-written word has not yet been taken by the processor;
- a receive-full flag, set while a processor word is waiting to be read.

A guarded command register gives the host a way to raise a processor interrupt. The register carries a 7-bit vector.

The host bus is configured through host-visible registers:
- plain or multiplexed address/data;
- one data strobe with a read/write line, or separate read and write strobes;
- one shared request line or separate transmit and receive request lines;
- push-pull or open-drain request outputs;
- programmable polarity for every control pin.

Every host control pin passes through a two-flop synchronizer. Accesses are recognized from edges in the processor clock domain. A write commits when its strobe is released. A read drives data while its strobe is held and applies its side effects when the strobe is released.

Top module: `host_port_bridge`

## Requirements
- R1: After reset:
  - the word-pending indication is clear (`procRxValid`=0) and `procTxReady`=1;
  - `cmdIrq`=0 and `hostDataOe`=0;
  - every control pin is treated as active-low;
  - the bus is in plain-address, single-strobe, single-request, push-pull mode, so both request pins sit at 1 with output enable 1.
- R2: Host register addresses 5, 6 and 7 are the high, middle and low bytes. Writing address 7 while no word is pending presents {high, middle, low} on `procRxData` with `procRxValid`=1. The word is released when `procRxReady` is sampled high.
- R3: While a word is pending, host writes to addresses 5, 6 and 7 are ignored. The pending word stays unchanged, and the staged high and middle bytes keep their earlier values for the next word.
- R4: While the receive-full flag is clear, `procTxReady` is 1 and a `procTxValid` beat loads the word and sets the flag. Reads of addresses 5, 6 and 7 then return its high, middle and low bytes. The read of address 7 clears the flag.
- R5: Address 2 reads status:
  - bit 0 is receive-full;
  - bit 1 is transmit-empty (no word pending);
  - bit 2 is command-pending;
  - other bits are 0.

  Address 4 reads 0.
- R6: Address 3 holds {command bit, 7-bit vector}. A host write loads both only while the command bit is clear, and is ignored otherwise. `cmdIrq` follows the command bit and `cmdVector` the vector. A `cmdAck` pulse clears the command bit.
- R7: Mode register (address 0) bit 1 selects double-strobe mode. In that mode the separate read and write strobes are used, and activity on the single data strobe is ignored. In single-strobe mode, the read/write line at 1 means read.
- R8: Mode bit 0 selects multiplexed mode. The register address is taken from host data lines [2:0] at the active edge of the address strobe, and the address pins are ignored.
- R9: Request routing depends on mode bit 2:
  - Single-request mode (bit 2 = 0): request A is active while receive-full is set and the acknowledge input is inactive, and request B stays inactive.
  - Double-request mode (bit 2 = 1): request A shows transmit-empty and request B shows receive-full.
- R10: Polarity register (address 1) bits select active-high (1) or active-low (0) for:
  - bit 0: chip select;
  - bit 1: address strobe;
  - bit 2: all data strobes;
  - bit 3: request outputs;
  - bit 4: acknowledge.
- R11: Mode bit 3 selects open-drain requests: each request output enable is 1 only while that request pin is at 0. In push-pull mode both enables are 1.
- R12: `hostDataOe` is 1 only while a read access (chip select plus read strobe) is seen, and is 0 during writes and idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low reset |
| hostCsPin | input | 1 | Host chip select |
| hostAsPin | input | 1 | Host address strobe (multiplexed mode) |
| hostDsPin | input | 1 | Host data strobe (single-strobe mode) |
| hostRwPin | input | 1 | Host read/write line, 1 = read |
| hostRdPin | input | 1 | Host read strobe (double-strobe mode) |
| hostWrPin | input | 1 | Host write strobe (double-strobe mode) |
| hostAckPin | input | 1 | Host acknowledge |
| hostAddr | input | 3 | Register address (plain mode) |
| hostDataIn | input | 8 | Host data / multiplexed address in |
| hostDataOut | output | 8 | Host read data |
| hostDataOe | output | 1 | Drive enable for host read data |
| hostReqA | output | 1 | Shared or transmit request pin level |
| hostReqAOe | output | 1 | Request A output enable |
| hostReqB | output | 1 | Receive request pin level |
| hostReqBOe | output | 1 | Request B output enable |
| procRxData | output | 24 | Word written by the host |
| procRxValid | output | 1 | Host word pending |
| procRxReady | input | 1 | Processor takes the host word |
| procTxData | input | 24 | Word for the host |
| procTxValid | input | 1 | Processor word offered |
| procTxReady | output | 1 | Receive registers free |
| cmdIrq | output | 1 | Host command interrupt |
| cmdVector | output | 7 | Host command vector |
| cmdAck | input | 1 | Processor clears the command |

## Verification
The byte path is tried with distinct byte values in each position, so that a swapped or dropped byte shows up in the assembled word. Writes issued while a word is still pending check that the flag gate discards them without damaging the staged bytes. The bus modes are crossed one at a time:
- a stray single-strobe pulse in double-strobe mode;
- wrong address pins in multiplexed mode;
- a full word transfer with every polarity inverted.

Each of these fails visibly if the mode decode or the polarity normalization is wrong. A behavioural model holding a queue of expected words and the flag states is compared with the processor-side outputs on every quiet clock.

// File: rtl/hpb_pkg.sv
package hpb_pkg;
  localparam int BYTE_W = 8;
  localparam int BYTES = 3;
  localparam int WORD_W = BYTE_W * BYTES;
  localparam int ADDR_W = 3;
  localparam int VEC_W = BYTE_W - 1;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_POL = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CMD = 3'd3;
  localparam int ADDR_BYTE_BASE = 5;

  typedef struct packed {
    logic mux;
    logic dualStrobe;
    logic dualReq;
    logic openDrain;
    logic polCs;
    logic polAs;
    logic polStrobe;
    logic polReq;
    logic polAck;
  } hpbCfg_t;

  typedef struct packed {
    logic wrCommit;
    logic rdCommit;
    logic rdActive;
    logic ackActive;
    logic [ADDR_W-1:0] regSel;
    logic [BYTE_W-1:0] wrByte;
  } hpbStrobes_t;
endpackage

// File: rtl/hpb_sync.sv
module hpb_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stageQ[s] <= RESET_VAL;
          else        stageQ[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stageQ[s] <= RESET_VAL;
          else        stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/hpb_ctrl.sv
module hpb_ctrl
  import hpb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic muxMode,
  input  logic dualStrobe,
  input  logic polCs,
  input  logic polAs,
  input  logic polStrobe,
  input  logic polAck,
  input  logic cfgTouched,
  input  logic pinCs,
  input  logic pinAs,
  input  logic pinDs,
  input  logic pinRw,
  input  logic pinRd,
  input  logic pinWr,
  input  logic pinAck,
  input  logic [ADDR_W-1:0] pinAddr,
  input  logic [BYTE_W-1:0] pinData,
  output hpbStrobes_t strobes
);
  localparam int NUM_CTRL = 7;
  localparam int IDX_CS = 0, IDX_AS = 1, IDX_DS = 2, IDX_RW = 3;
  localparam int IDX_RD = 4, IDX_WR = 5, IDX_ACK = 6;

  logic [NUM_CTRL-1:0] rawPins, syncPins;
  assign rawPins = {pinAck, pinWr, pinRd, pinRw, pinDs, pinAs, pinCs};

  hpb_sync #(
    .WIDTH(NUM_CTRL),
    .STAGES(SYNC_STAGES),
    .RESET_VAL({NUM_CTRL{1'b1}})
  ) ctrlSync_i (
    .clk(clk),
    .rst_n(rst_n),
    .asyncIn(rawPins),
    .syncOut(syncPins)
  );

  function automatic logic isActive(input logic level, input logic polHigh);
    return ~(level ^ polHigh);
  endfunction

  logic csAct, asAct, dsAct, rdPinAct, wrPinAct, ackAct, rwRead;
  logic rdReq, wrReq, accRd, accWr;
  logic quiet, prevRd, prevWr, prevAs;
  logic [ADDR_W-1:0] latchAddr;

  assign csAct    = isActive(syncPins[IDX_CS], polCs);
  assign asAct    = isActive(syncPins[IDX_AS], polAs);
  assign dsAct    = isActive(syncPins[IDX_DS], polStrobe);
  assign rdPinAct = isActive(syncPins[IDX_RD], polStrobe);
  assign wrPinAct = isActive(syncPins[IDX_WR], polStrobe);
  assign ackAct   = isActive(syncPins[IDX_ACK], polAck);
  assign rwRead   = syncPins[IDX_RW];

  assign rdReq = dualStrobe ? rdPinAct : (dsAct & rwRead);
  assign wrReq = dualStrobe ? wrPinAct : (dsAct & ~rwRead);
  assign accRd = csAct & rdReq & ~quiet;
  assign accWr = csAct & wrReq & ~quiet;

  // After a configuration change, wait for chip select to look idle under
  // the new settings so a flipped polarity cannot fake an access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet     <= 1'b0;
      prevRd    <= 1'b0;
      prevWr    <= 1'b0;
      prevAs    <= 1'b0;
      latchAddr <= '0;
    end else begin
      if (cfgTouched) quiet <= 1'b1;
      else if (!csAct) quiet <= 1'b0;
      prevRd <= accRd;
      prevWr <= accWr;
      prevAs <= asAct;
      if (muxMode && asAct && !prevAs) latchAddr <= pinData[ADDR_W-1:0];
    end
  end

  always_comb begin
    strobes.wrCommit  = prevWr & ~accWr;
    strobes.rdCommit  = prevRd & ~accRd;
    strobes.rdActive  = accRd;
    strobes.ackActive = ackAct;
    strobes.regSel    = muxMode ? latchAddr : pinAddr;
    strobes.wrByte    = pinData;
  end
endmodule

// File: rtl/hpb_datapath.sv
module hpb_datapath
  import hpb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  hpbStrobes_t strobes,
  output hpbCfg_t cfg,
  output logic cfgTouched,
  output logic [BYTE_W-1:0] hostDataOut,
  output logic hostDataOe,
  output logic reqA,
  output logic reqAOe,
  output logic reqB,
  output logic reqBOe,
  output logic [WORD_W-1:0] procRxData,
  output logic procRxValid,
  input  logic procRxReady,
  input  logic [WORD_W-1:0] procTxData,
  input  logic procTxValid,
  output logic procTxReady,
  output logic cmdIrq,
  output logic [VEC_W-1:0] cmdVector,
  input  logic cmdAck
);
  localparam int MODE_W = 4;
  localparam int POL_W = 5;

  logic [MODE_W-1:0] modeReg;
  logic [POL_W-1:0] polReg;
  logic [BYTES-1:0] byteHit;
  logic [BYTE_W-1:0] txStage [BYTES-1];
  logic [WORD_W-1:0] txAssembled, txWord, rxWord;
  logic txEmpty, rxFull, cmdPend;
  logic [VEC_W-1:0] cmdVec;
  logic lowWrite, lowRead, loadRx, cmdWrite;
  logic reqAAct, reqBAct;
  logic [BYTE_W-1:0] rdByte;

  generate
    for (genvar k = 0; k < BYTES; k++) begin : g_hit
      assign byteHit[k] = (strobes.regSel == ADDR_W'(ADDR_BYTE_BASE + k));
    end
    for (genvar k = 0; k < BYTES - 1; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) txStage[k] <= '0;
        else if (strobes.wrCommit && byteHit[k] && txEmpty) txStage[k] <= strobes.wrByte;
      end
    end
  endgenerate

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeReg <= '0;
      polReg  <= '0;
    end else if (strobes.wrCommit) begin
      if (strobes.regSel == ADDR_MODE) modeReg <= strobes.wrByte[MODE_W-1:0];
      if (strobes.regSel == ADDR_POL)  polReg  <= strobes.wrByte[POL_W-1:0];
    end
  end

  assign cfgTouched = strobes.wrCommit &
                      ((strobes.regSel == ADDR_MODE) | (strobes.regSel == ADDR_POL));

  always_comb begin
    cfg.mux        = modeReg[0];
    cfg.dualStrobe = modeReg[1];
    cfg.dualReq    = modeReg[2];
    cfg.openDrain  = modeReg[3];
    cfg.polCs      = polReg[0];
    cfg.polAs      = polReg[1];
    cfg.polStrobe  = polReg[2];
    cfg.polReq     = polReg[3];
    cfg.polAck     = polReg[4];
  end

  // Host-to-processor word
  always_comb begin
    txAssembled = '0;
    for (int k = 0; k < BYTES - 1; k++) begin
      txAssembled[(BYTES-1-k)*BYTE_W +: BYTE_W] = txStage[k];
    end
    txAssembled[BYTE_W-1:0] = strobes.wrByte;
  end

  assign lowWrite = strobes.wrCommit & byteHit[BYTES-1] & txEmpty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txWord  <= '0;
      txEmpty <= 1'b1;
    end else if (lowWrite) begin
      txWord  <= txAssembled;
      txEmpty <= 1'b0;
    end else if (!txEmpty && procRxReady) begin
      txEmpty <= 1'b1;
    end
  end

  // Processor-to-host word
  assign loadRx  = procTxValid & ~rxFull;
  assign lowRead = strobes.rdCommit & byteHit[BYTES-1] & rxFull;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxWord <= '0;
      rxFull <= 1'b0;
    end else if (loadRx) begin
      rxWord <= procTxData;
      rxFull <= 1'b1;
    end else if (lowRead) begin
      rxFull <= 1'b0;
    end
  end

  // Guarded command register
  assign cmdWrite = strobes.wrCommit & (strobes.regSel == ADDR_CMD) & ~cmdPend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdPend <= 1'b0;
      cmdVec  <= '0;
    end else if (cmdWrite) begin
      {cmdPend, cmdVec} <= strobes.wrByte;
    end else if (cmdAck) begin
      cmdPend <= 1'b0;
    end
  end

  // Host read mux
  always_comb begin
    rdByte = '0;
    case (strobes.regSel)
      ADDR_MODE: rdByte = BYTE_W'(modeReg);
      ADDR_POL:  rdByte = BYTE_W'(polReg);
      ADDR_STAT: rdByte = BYTE_W'({cmdPend, txEmpty, rxFull});
      ADDR_CMD:  rdByte = {cmdPend, cmdVec};
      default:   rdByte = '0;
    endcase
    for (int k = 0; k < BYTES; k++) begin
      if (byteHit[k]) rdByte = rxWord[(BYTES-1-k)*BYTE_W +: BYTE_W];
    end
  end

  assign hostDataOut = rdByte;
  assign hostDataOe  = strobes.rdActive;

  // Request lines
  assign reqAAct = cfg.dualReq ? txEmpty : (rxFull & ~strobes.ackActive);
  assign reqBAct = cfg.dualReq & rxFull;
  assign reqA    = ~(reqAAct ^ cfg.polReq);
  assign reqB    = ~(reqBAct ^ cfg.polReq);
  assign reqAOe  = cfg.openDrain ? ~reqA : 1'b1;
  assign reqBOe  = cfg.openDrain ? ~reqB : 1'b1;

  assign procRxData  = txWord;
  assign procRxValid = ~txEmpty;
  assign procTxReady = ~rxFull;
  assign cmdIrq      = cmdPend;
  assign cmdVector   = cmdVec;

  AST_LOW_WRITE_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.wrCommit && byteHit[BYTES-1] && txEmpty |=> procRxValid); // R2
  AST_HELD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    procRxValid && !procRxReady |=> procRxValid && $stable(procRxData)); // R3
  AST_RX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    procTxValid && procTxReady |=> !procTxReady); // R4
  AST_VECTOR_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
    cmdIrq |=> (!cmdIrq || $stable(cmdVector))); // R6
  AST_OPEN_DRAIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.openDrain && reqAOe |-> !reqA); // R11
endmodule

// File: rtl/host_port_bridge.sv
module host_port_bridge
  import hpb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hostCsPin,
  input  logic hostAsPin,
  input  logic hostDsPin,
  input  logic hostRwPin,
  input  logic hostRdPin,
  input  logic hostWrPin,
  input  logic hostAckPin,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [BYTE_W-1:0] hostDataIn,
  output logic [BYTE_W-1:0] hostDataOut,
  output logic hostDataOe,
  output logic hostReqA,
  output logic hostReqAOe,
  output logic hostReqB,
  output logic hostReqBOe,
  output logic [WORD_W-1:0] procRxData,
  output logic procRxValid,
  input  logic procRxReady,
  input  logic [WORD_W-1:0] procTxData,
  input  logic procTxValid,
  output logic procTxReady,
  output logic cmdIrq,
  output logic [VEC_W-1:0] cmdVector,
  input  logic cmdAck
);
  hpbCfg_t cfg;
  hpbStrobes_t strobes;
  logic cfgTouched;

  hpb_ctrl #(.SYNC_STAGES(2)) ctrl_i (
    .clk(clk),
    .rst_n(rst_n),
    .muxMode(cfg.mux),
    .dualStrobe(cfg.dualStrobe),
    .polCs(cfg.polCs),
    .polAs(cfg.polAs),
    .polStrobe(cfg.polStrobe),
    .polAck(cfg.polAck),
    .cfgTouched(cfgTouched),
    .pinCs(hostCsPin),
    .pinAs(hostAsPin),
    .pinDs(hostDsPin),
    .pinRw(hostRwPin),
    .pinRd(hostRdPin),
    .pinWr(hostWrPin),
    .pinAck(hostAckPin),
    .pinAddr(hostAddr),
    .pinData(hostDataIn),
    .strobes(strobes)
  );

  hpb_datapath datapath_i (
    .clk(clk),
    .rst_n(rst_n),
    .strobes(strobes),
    .cfg(cfg),
    .cfgTouched(cfgTouched),
    .hostDataOut(hostDataOut),
    .hostDataOe(hostDataOe),
    .reqA(hostReqA),
    .reqAOe(hostReqAOe),
    .reqB(hostReqB),
    .reqBOe(hostReqBOe),
    .procRxData(procRxData),
    .procRxValid(procRxValid),
    .procRxReady(procRxReady),
    .procTxData(procTxData),
    .procTxValid(procTxValid),
    .procTxReady(procTxReady),
    .cmdIrq(cmdIrq),
    .cmdVector(cmdVector),
    .cmdAck(cmdAck)
  );
endmodule

// File: tb/host_port_bridge_tb_top.sv
module host_port_bridge_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hostCsPin, hostAsPin, hostDsPin, hostRwPin, hostRdPin, hostWrPin, hostAckPin;
  logic [2:0] hostAddr;
  logic [7:0] hostDataIn, hostDataOut;
  logic hostDataOe, hostReqA, hostReqAOe, hostReqB, hostReqBOe;
  logic [23:0] procRxData, procTxData;
  logic procRxValid, procRxReady, procTxValid, procTxReady;
  logic cmdIrq, cmdAck;
  logic [6:0] cmdVector;

  always #2 clk = ~clk;

  host_port_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .hostCsPin(hostCsPin), .hostAsPin(hostAsPin), .hostDsPin(hostDsPin),
    .hostRwPin(hostRwPin), .hostRdPin(hostRdPin), .hostWrPin(hostWrPin),
    .hostAckPin(hostAckPin), .hostAddr(hostAddr), .hostDataIn(hostDataIn),
    .hostDataOut(hostDataOut), .hostDataOe(hostDataOe),
    .hostReqA(hostReqA), .hostReqAOe(hostReqAOe),
    .hostReqB(hostReqB), .hostReqBOe(hostReqBOe),
    .procRxData(procRxData), .procRxValid(procRxValid), .procRxReady(procRxReady),
    .procTxData(procTxData), .procTxValid(procTxValid), .procTxReady(procTxReady),
    .cmdIrq(cmdIrq), .cmdVector(cmdVector), .cmdAck(cmdAck)
  );

  int nChecks = 0;
  int nBad = 0;
  bit started = 0;
  bit busy = 0;
  bit finished = 0;

  // Bench view of bus configuration
  bit bMux = 0;
  bit bDual = 0;
  bit bPol = 0;

  // Behavioural reference model
  logic [23:0] expQ[$];
  logic [7:0] mHi = 8'h00, mMid = 8'h00;
  bit mRxFull = 0;
  bit mCmd = 0;
  logic [6:0] mVec = 7'h00;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic lvl(input logic act);
    return bPol ? act : ~act;
  endfunction

  task automatic idlePins();
    hostCsPin  = lvl(1'b0);
    hostAsPin  = lvl(1'b0);
    hostDsPin  = lvl(1'b0);
    hostRdPin  = lvl(1'b0);
    hostWrPin  = lvl(1'b0);
    hostAckPin = lvl(1'b0);
    hostRwPin  = 1'b1;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic addrPhase(input logic [2:0] a);
    if (bMux) begin
      hostAddr   = ~a;
      hostDataIn = {5'b0, a};
      hostAsPin  = lvl(1'b1);
      waitN(4);
      hostAsPin  = lvl(1'b0);
      waitN(3);
    end else begin
      hostAddr = a;
    end
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [7:0] d);
    busy = 1;
    @(negedge clk);
    addrPhase(a);
    hostDataIn = d;
    hostRwPin  = 1'b0;
    hostCsPin  = lvl(1'b1);
    if (bDual) hostWrPin = lvl(1'b1);
    else       hostDsPin = lvl(1'b1);
    waitN(5);
    chk("R12 no drive during write", hostDataOe, 1'b0);
    hostCsPin = lvl(1'b0);
    hostWrPin = lvl(1'b0);
    hostDsPin = lvl(1'b0);
    waitN(6);
    hostRwPin = 1'b1;
    if (a == 3'd5 && expQ.size() == 0) mHi = d;
    if (a == 3'd6 && expQ.size() == 0) mMid = d;
    if (a == 3'd7 && expQ.size() == 0) expQ.push_back({mHi, mMid, d});
    if (a == 3'd3 && !mCmd) begin
      mCmd = d[7];
      mVec = d[6:0];
    end
    busy = 0;
  endtask

  task automatic hostRead(input logic [2:0] a, input logic [7:0] exp, input string tag);
    busy = 1;
    @(negedge clk);
    addrPhase(a);
    hostRwPin = 1'b1;
    hostCsPin = lvl(1'b1);
    if (bDual) hostRdPin = lvl(1'b1);
    else       hostDsPin = lvl(1'b1);
    waitN(5);
    chk("R12 drive during read", hostDataOe, 1'b1);
    chk(tag, hostDataOut, exp);
    hostCsPin = lvl(1'b0);
    hostRdPin = lvl(1'b0);
    hostDsPin = lvl(1'b0);
    waitN(6);
    if (a == 3'd7) mRxFull = 0;
    busy = 0;
  endtask

  task automatic procConsume();
    busy = 1;
    @(negedge clk);
    procRxReady = 1'b1;
    @(negedge clk);
    procRxReady = 1'b0;
    if (expQ.size() != 0) void'(expQ.pop_front());
    waitN(1);
    busy = 0;
  endtask

  task automatic procSend(input logic [23:0] w);
    busy = 1;
    @(negedge clk);
    procTxData  = w;
    procTxValid = 1'b1;
    @(negedge clk);
    procTxValid = 1'b0;
    mRxFull = 1;
    waitN(1);
    busy = 0;
  endtask

  task automatic ackCmd();
    busy = 1;
    @(negedge clk);
    cmdAck = 1'b1;
    @(negedge clk);
    cmdAck = 1'b0;
    mCmd = 0;
    waitN(1);
    busy = 0;
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (started && !busy && !finished) begin
      chk("R2 model pending", procRxValid, expQ.size() != 0);
      if (expQ.size() != 0) chk("R2 model word", procRxData, expQ[0]);
      chk("R4 model ready", procTxReady, !mRxFull);
      chk("R6 model irq", cmdIrq, mCmd);
      if (mCmd) chk("R6 model vector", cmdVector, mVec);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nBad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    idlePins();
    hostAddr = 3'd0;
    hostDataIn = 8'h00;
    procRxReady = 1'b0;
    procTxValid = 1'b0;
    procTxData = 24'h0;
    cmdAck = 1'b0;
    waitN(4);
    rst_n = 1'b1;
    waitN(3);
    started = 1;

    // R1 reset state
    chk("R1 pending", procRxValid, 1'b0);
    chk("R1 tx ready", procTxReady, 1'b1);
    chk("R1 irq", cmdIrq, 1'b0);
    chk("R1 data oe", hostDataOe, 1'b0);
    chk("R1 reqA", {hostReqA, hostReqAOe}, 2'b11);
    chk("R1 reqB", {hostReqB, hostReqBOe}, 2'b11);

    hostRead(3'd2, 8'h02, "R5 status idle");
    hostRead(3'd4, 8'h00, "R5 unused address");

    // R2 word assembly
    hostWrite(3'd5, 8'hA1);
    hostWrite(3'd6, 8'hB2);
    hostWrite(3'd7, 8'hC3);
    chk("R2 valid", procRxValid, 1'b1);
    chk("R2 word", procRxData, 24'hA1B2C3);
    hostRead(3'd2, 8'h00, "R5 status pending");

    // R3 writes while pending are ignored
    hostWrite(3'd5, 8'h99);
    hostWrite(3'd7, 8'h55);
    chk("R3 word held", procRxData, 24'hA1B2C3);
    procConsume();
    chk("R2 released", procRxValid, 1'b0);
    hostWrite(3'd7, 8'h11);
    chk("R3 staged bytes kept", procRxData, 24'hA1B211);
    procConsume();

    // R4 processor to host, R9 single request with acknowledge
    procSend(24'h123456);
    chk("R4 ready dropped", procTxReady, 1'b0);
    hostRead(3'd2, 8'h03, "R5 status full");
    chk("R9 single request active", hostReqA, 1'b0);
    busy = 1;
    hostAckPin = lvl(1'b1);
    waitN(4);
    chk("R9 ack masks request", hostReqA, 1'b1);
    hostAckPin = lvl(1'b0);
    waitN(4);
    chk("R9 request back", hostReqA, 1'b0);
    busy = 0;
    hostRead(3'd5, 8'h12, "R4 high byte");
    hostRead(3'd6, 8'h34, "R4 middle byte");
    chk("R4 still full", procTxReady, 1'b0);
    hostRead(3'd7, 8'h56, "R4 low byte");
    chk("R4 low read frees", procTxReady, 1'b1);
    chk("R9 request idle", hostReqA, 1'b1);

    // R6 guarded command
    hostWrite(3'd3, 8'hAA);
    chk("R6 irq set", cmdIrq, 1'b1);
    chk("R6 vector", cmdVector, 7'h2A);
    hostRead(3'd3, 8'hAA, "R6 readback");
    hostWrite(3'd3, 8'h85);
    chk("R6 vector guarded", cmdVector, 7'h2A);
    ackCmd();
    chk("R6 ack clears", cmdIrq, 1'b0);
    hostWrite(3'd3, 8'h07);
    hostRead(3'd3, 8'h07, "R6 vector only");

    // R7 double strobe
    hostWrite(3'd0, 8'h02);
    bDual = 1;
    idlePins();
    busy = 1;
    @(negedge clk);
    hostAddr = 3'd3;
    hostDataIn = 8'h93;
    hostRwPin = 1'b0;
    hostCsPin = lvl(1'b1);
    hostDsPin = lvl(1'b1);
    waitN(5);
    hostCsPin = lvl(1'b0);
    hostDsPin = lvl(1'b0);
    waitN(6);
    hostRwPin = 1'b1;
    busy = 0;
    chk("R7 stray strobe no irq", cmdIrq, 1'b0);
    hostRead(3'd3, 8'h07, "R7 stray strobe ignored");
    hostRead(3'd0, 8'h02, "R7 mode readback");

    // R9 double request
    hostWrite(3'd0, 8'h06);
    chk("R9 dual reqA tx empty", hostReqA, 1'b0);
    chk("R9 dual reqB idle", hostReqB, 1'b1);

    // R11 open drain
    hostWrite(3'd0, 8'h0E);
    chk("R11 oe A low level", hostReqAOe, 1'b1);
    chk("R11 oe B high level", hostReqBOe, 1'b0);

    // R10 all polarities active-high
    hostWrite(3'd1, 8'h1F);
    bPol = 1;
    idlePins();
    waitN(6);
    chk("R10 reqA high active", hostReqA, 1'b1);
    chk("R11 oe released", hostReqAOe, 1'b0);
    chk("R10 reqB low idle", {hostReqB, hostReqBOe}, 2'b01);
    hostWrite(3'd5, 8'h0D);
    hostWrite(3'd6, 8'h0E);
    hostWrite(3'd7, 8'h0F);
    chk("R10 word active-high", procRxData, 24'h0D0E0F);
    chk("R10 reqA dropped", hostReqA, 1'b0);
    procConsume();
    hostRead(3'd1, 8'h1F, "R10 polarity readback");
    hostWrite(3'd1, 8'h00);
    bPol = 0;
    idlePins();
    waitN(6);

    // R8 multiplexed address
    hostWrite(3'd0, 8'h01);
    bDual = 0;
    bMux = 1;
    idlePins();
    waitN(4);
    hostWrite(3'd3, 8'hB3);
    chk("R8 mux command", cmdIrq, 1'b1);
    chk("R8 mux vector", cmdVector, 7'h33);
    hostRead(3'd3, 8'hB3, "R8 mux read");
    hostRead(3'd2, 8'h06, "R5 status command");
    hostRead(3'd0, 8'h01, "R8 mode kept");

    waitN(4);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end
endmodule